// File: doc/BRIEF.md
# Scan-Doubling Grayscale Raster Generator

This block produces the timing for a 640×480 raster monitor. It also turns a small 32×32 grayscale picture into an enlarged on-screen window. Its pixel rate is half the system clock rate. Two scan counters, one for the column and one for the line, set the sync pulses and the blanking interval. A small address unit derives the frame-buffer read address from the upper bits of those counters. Each stored pixel therefore covers a square of 8×8 screen pixels, so the picture fills a 256×256 window at the top-left corner of the visible area.

The frame buffer sits outside the block and returns data one system clock after it sees an address. The block registers the sync outputs, the blank output and the gray output together in one output stage, one pixel after the counter position that produced them. This keeps the outputs aligned with the returned data. Screen positions outside the window, and every blanked position, show black. All timing limits are parameters. The defaults below give the standard 640×480 raster.

Top module: `vga_replicate_display`

## Requirements
- R1: The scan position advances by exactly one step every two system clock cycles, so one line of H_TOTAL=800 columns lasts 1600 system clocks.
- R2: The column count runs 0 to H_TOTAL-1 (default 800) and then wraps. The line count advances only when the column wraps and runs 0 to V_TOTAL-1 (default 521), so one frame lasts 2·H_TOTAL·V_TOTAL system clocks.
- R3: `hsync_n` is low, meaning active, for columns 656 through 751 inclusive (96 pixels, 192 system clocks) and high for all other columns.
- R4: `vsync_n` is low for lines 490 and 491 only.
- R5: `blank` is 1 exactly when the column is 640 or more, or the line is 480 or more.
- R6: Inside the window (column < 256 and line < 256) and outside blanking, `gray` equals the frame-buffer word of source pixel (line/8, column/8). Each source pixel therefore fills an 8×8 block.
- R7: `gray` is 0 during blanking and at every visible position outside the window.
- R8: `fb_addr` equals (line/8)·32 + column/8 for the current scan position inside the window, with the line part in the upper five bits. Outside the window it is 0.
- R9: `hsync_n`, `vsync_n`, `blank` and `gray` all describe the same pixel. They are registered one pixel after the scan position that addresses the frame buffer, and the read data is taken one system clock after the address.
- R10: While `rst_n` is low, `hsync_n`=1, `vsync_n`=1, `blank`=1, `gray`=0 and `fb_addr`=0, and the scan restarts at column 0, line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| fb_rdata | input | 8 | Frame-buffer read data, one clock after `fb_addr` |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| blank | output | 1 | High outside the visible 640×480 area |
| gray | output | 8 | Gray level of the current pixel |
| fb_addr | output | 10 | Frame-buffer read address, line part in the upper bits |

## Verification
The hardest behaviour to reach from the ports is the vertical part of the raster. A full default frame lasts more than 830,000 clocks, so the bench keeps the horizontal defaults and shortens the vertical total, the active lines and the source picture through parameters. In this smaller configuration, a complete frame still covers the line wrap, the vertical sync and the unblanked lines below the window. The bench locks onto the falling edge of vertical sync and models the frame buffer with a word pattern that is never zero. It then predicts every output sample over one whole frame from the pixel index alone, so any misaligned, replicated or black pixel shows up.

// File: rtl/vgd_pkg.sv
package vgd_pkg;

  // true when lo <= v < hi
  function automatic logic span_hit(input int unsigned v, input int unsigned lo,
                                    input int unsigned hi);
    return (v >= lo) && (v < hi);
  endfunction

  // linear source index of a screen position: line block above column block
  function automatic int unsigned src_index(input int unsigned col, input int unsigned row,
                                            input int unsigned sh, input int unsigned dim);
    return (row >> sh) * dim + (col >> sh);
  endfunction

endpackage

// File: rtl/vgd_pix_strobe.sv
module vgd_pix_strobe (
  input  logic clk,
  input  logic rst_n,
  output logic pix_en
);
  logic phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= ~phase_q;
  end

  assign pix_en = phase_q;
endmodule

// File: rtl/vgd_scan_ctr.sv
module vgd_scan_ctr #(
  parameter int H_TOTAL = 800,
  parameter int V_TOTAL = 521,
  localparam int COL_W = $clog2(H_TOTAL),
  localparam int ROW_W = $clog2(V_TOTAL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_en,
  output logic [COL_W-1:0] col,
  output logic [ROW_W-1:0] row,
  output logic             line_end
);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(H_TOTAL - 1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(V_TOTAL - 1);

  assign line_end = (col == COL_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col <= '0;
      row <= '0;
    end else if (pix_en) begin
      if (line_end) begin
        col <= '0;
        row <= (row == ROW_LAST) ? '0 : row + 1'b1;
      end else begin
        col <= col + 1'b1;
      end
    end
  end
endmodule

// File: rtl/vgd_addr_gen.sv
module vgd_addr_gen #(
  parameter int COL_W   = 10,
  parameter int ROW_W   = 10,
  parameter int SRC_DIM = 32,
  parameter int SCALE   = 8,
  localparam int SH     = $clog2(SCALE),
  localparam int WIN    = SRC_DIM * SCALE,
  localparam int ADDR_W = 2 * $clog2(SRC_DIM)
) (
  input  logic [COL_W-1:0]  col,
  input  logic [ROW_W-1:0]  row,
  output logic              in_win,
  output logic [ADDR_W-1:0] fb_addr
);
  import vgd_pkg::*;

  assign in_win = span_hit(32'(col), 0, WIN) && span_hit(32'(row), 0, WIN);

  always_comb begin
    if (in_win) fb_addr = ADDR_W'(src_index(32'(col), 32'(row), SH, SRC_DIM));
    else        fb_addr = '0;
  end
endmodule

// File: rtl/vgd_out_stage.sv
module vgd_out_stage #(
  parameter int COL_W    = 10,
  parameter int ROW_W    = 10,
  parameter int PIX_W    = 8,
  parameter int H_ACTIVE = 640,
  parameter int HS_START = 656,
  parameter int HS_END   = 752,
  parameter int V_ACTIVE = 480,
  parameter int VS_START = 490,
  parameter int VS_END   = 492
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_en,
  input  logic [COL_W-1:0] col,
  input  logic [ROW_W-1:0] row,
  input  logic             in_win,
  input  logic [PIX_W-1:0] fb_rdata,
  output logic             hsync_n,
  output logic             vsync_n,
  output logic             blank,
  output logic [PIX_W-1:0] gray
);
  import vgd_pkg::*;

  logic hs_hit, vs_hit, vis;
  assign hs_hit = span_hit(32'(col), HS_START, HS_END);
  assign vs_hit = span_hit(32'(row), VS_START, VS_END);
  assign vis    = span_hit(32'(col), 0, H_ACTIVE) && span_hit(32'(row), 0, V_ACTIVE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hsync_n <= 1'b1;
      vsync_n <= 1'b1;
      blank   <= 1'b1;
      gray    <= '0;
    end else if (pix_en) begin
      hsync_n <= ~hs_hit;
      vsync_n <= ~vs_hit;
      blank   <= ~vis;
      gray    <= (vis && in_win) ? fb_rdata : '0;
    end
  end
endmodule

// File: rtl/vga_replicate_display.sv
module vga_replicate_display #(
  parameter int H_TOTAL  = 800,
  parameter int H_ACTIVE = 640,
  parameter int HS_START = 656,
  parameter int HS_END   = 752,
  parameter int V_TOTAL  = 521,
  parameter int V_ACTIVE = 480,
  parameter int VS_START = 490,
  parameter int VS_END   = 492,
  parameter int SRC_DIM  = 32,
  parameter int SCALE    = 8,
  parameter int PIX_W    = 8,
  localparam int COL_W   = $clog2(H_TOTAL),
  localparam int ROW_W   = $clog2(V_TOTAL),
  localparam int ADDR_W  = 2 * $clog2(SRC_DIM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PIX_W-1:0]  fb_rdata,
  output logic              hsync_n,
  output logic              vsync_n,
  output logic              blank,
  output logic [PIX_W-1:0]  gray,
  output logic [ADDR_W-1:0] fb_addr
);
  logic             pix_en;
  logic [COL_W-1:0] col;
  logic [ROW_W-1:0] row;
  logic             line_end;
  logic             in_win;

  vgd_pix_strobe u_strobe (.clk(clk), .rst_n(rst_n), .pix_en(pix_en));

  vgd_scan_ctr #(.H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL)) u_scan (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en),
    .col(col), .row(row), .line_end(line_end)
  );

  vgd_addr_gen #(.COL_W(COL_W), .ROW_W(ROW_W), .SRC_DIM(SRC_DIM), .SCALE(SCALE)) u_addr (
    .col(col), .row(row), .in_win(in_win), .fb_addr(fb_addr)
  );

  vgd_out_stage #(
    .COL_W(COL_W), .ROW_W(ROW_W), .PIX_W(PIX_W),
    .H_ACTIVE(H_ACTIVE), .HS_START(HS_START), .HS_END(HS_END),
    .V_ACTIVE(V_ACTIVE), .VS_START(VS_START), .VS_END(VS_END)
  ) u_out (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .col(col), .row(row),
    .in_win(in_win), .fb_rdata(fb_rdata),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .blank(blank), .gray(gray)
  );
endmodule

// File: rtl/vgd_checker.sv
module vgd_checker #(
  parameter int H_TOTAL  = 800,
  parameter int H_ACTIVE = 640,
  parameter int HS_START = 656,
  parameter int HS_END   = 752,
  parameter int V_ACTIVE = 480,
  parameter int VS_START = 490,
  parameter int VS_END   = 492,
  parameter int COL_W    = 10,
  parameter int ROW_W    = 10,
  parameter int PIX_W    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pix_en,
  input logic [COL_W-1:0] col,
  input logic [ROW_W-1:0] row,
  input logic             in_win,
  input logic [PIX_W-1:0] fb_rdata,
  input logic             hsync_n,
  input logic             vsync_n,
  input logic             blank,
  input logic [PIX_W-1:0] gray
);
  import vgd_pkg::*;

  AST_PIX_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en |=> !pix_en); // R1
  AST_SCAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> ($stable(col) && $stable(row))); // R1
  AST_COL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && 32'(col) == H_TOTAL - 1) |=> (col == '0)); // R2
  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && 32'(col) != H_TOTAL - 1) |=> $stable(row)); // R2
  AST_HSYNC_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en |=> (hsync_n == !span_hit(32'($past(col)), HS_START, HS_END))); // R3
  AST_VSYNC_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en |=> (vsync_n == !span_hit(32'($past(row)), VS_START, VS_END))); // R4
  AST_BLANK_AREA: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en |=> (blank == (32'($past(col)) >= H_ACTIVE || 32'($past(row)) >= V_ACTIVE))); // R5
  AST_GRAY_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && in_win && 32'(col) < H_ACTIVE && 32'(row) < V_ACTIVE)
      |=> (gray == $past(fb_rdata))); // R6
  AST_GRAY_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> (gray == '0)); // R7
endmodule

bind vga_replicate_display vgd_checker #(
  .H_TOTAL(H_TOTAL), .H_ACTIVE(H_ACTIVE), .HS_START(HS_START), .HS_END(HS_END),
  .V_ACTIVE(V_ACTIVE), .VS_START(VS_START), .VS_END(VS_END),
  .COL_W(COL_W), .ROW_W(ROW_W), .PIX_W(PIX_W)
) i_vgd_checker (
  .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .col(col), .row(row),
  .in_win(in_win), .fb_rdata(fb_rdata), .hsync_n(hsync_n), .vsync_n(vsync_n),
  .blank(blank), .gray(gray)
);

// File: tb/test_vga_replicate_display.sv
`timescale 1ns/1ps
module test_vga_replicate_display;
  localparam int H    = 800;
  localparam int HACT = 640;
  localparam int HS0  = 656;
  localparam int HS1  = 752;
  localparam int V    = 44;
  localparam int VACT = 36;
  localparam int VS0  = 38;
  localparam int VS1  = 40;
  localparam int DIM  = 4;
  localparam int SC   = 8;
  localparam int WIN  = DIM * SC;
  localparam int AW   = 4;
  localparam int FRAME_CLK = 2 * H * V;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    fb_rdata = 8'd0;
  logic          hsync_n, vsync_n, blank;
  logic [7:0]    gray;
  logic [AW-1:0] fb_addr;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk; // 50 MHz

  vga_replicate_display #(
    .V_TOTAL(V), .V_ACTIVE(VACT), .VS_START(VS0), .VS_END(VS1),
    .SRC_DIM(DIM), .SCALE(SC)
  ) i_vga_replicate_display (
    .clk(clk), .rst_n(rst_n), .fb_rdata(fb_rdata), .hsync_n(hsync_n),
    .vsync_n(vsync_n), .blank(blank), .gray(gray), .fb_addr(fb_addr)
  );

  // frame-buffer model: never-zero word per address, one clock of read latency
  function automatic logic [7:0] word_of(input int a);
    return 8'((a * 37) + 11);
  endfunction

  always @(posedge clk) fb_rdata <= word_of(int'(fb_addr));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(hsync_n === 1'b1, "R10 hsync_n in reset", int'(hsync_n), 1);
    check(vsync_n === 1'b1, "R10 vsync_n in reset", int'(vsync_n), 1);
    check(blank === 1'b1, "R10 blank in reset", int'(blank), 1);
    check(gray === 8'd0, "R10 gray in reset", int'(gray), 0);
    check(fb_addr === '0, "R10 fb_addr in reset", int'(fb_addr), 0);
    rst_n = 1'b1;
  endtask

  // R1, R3: line period and horizontal sync width in system clocks
  task automatic t_line_timing();
    int low_len, period;
    @(negedge clk);
    while (hsync_n !== 1'b1) @(negedge clk);
    while (hsync_n !== 1'b0) @(negedge clk);
    low_len = 0;
    period  = 0;
    while (hsync_n === 1'b0) begin low_len++; period++; @(negedge clk); end
    while (hsync_n === 1'b1) begin period++; @(negedge clk); end
    check(low_len == 2 * (HS1 - HS0), "R3 hsync low width", low_len, 2 * (HS1 - HS0));
    check(period == 2 * H, "R1 line period", period, 2 * H);
  endtask

  // R2, R4..R9: full-frame prediction from the pixel index
  task automatic t_frame_sweep();
    int mis_h, mis_v, mis_b, mis_g, mis_a, vs_low, p, c, ln, nc, nl;
    int gh, ge, ah, ae;
    bit eh, ev, eb;
    int eg, ea;
    mis_h = 0; mis_v = 0; mis_b = 0; mis_g = 0; mis_a = 0; vs_low = 0;
    gh = 0; ge = 0; ah = 0; ae = 0;
    while (vsync_n !== 1'b0) @(negedge clk);
    for (int t = 0; t < FRAME_CLK; t++) begin
      if (t > 0) @(negedge clk);
      p  = t / 2;
      c  = p % H;
      ln = (VS0 + p / H) % V;
      eh = !(c >= HS0 && c < HS1);
      ev = !(ln >= VS0 && ln < VS1);
      eb = (c >= HACT) || (ln >= VACT);
      eg = (!eb && c < WIN && ln < WIN) ? int'(word_of(((ln >> 3) << 2) | (c >> 3))) : 0;
      nc = (p + 1) % H;
      nl = (VS0 + (p + 1) / H) % V;
      ea = (nc < WIN && nl < WIN) ? (((nl >> 3) << 2) | (nc >> 3)) : 0;
      if (vsync_n === 1'b0) vs_low++;
      if (hsync_n !== eh) mis_h++;
      if (vsync_n !== ev) mis_v++;
      if (blank !== eb) mis_b++;
      if (gray !== 8'(eg)) begin
        if (mis_g == 0) begin gh = int'(gray); ge = eg; end
        mis_g++;
      end
      if (fb_addr !== AW'(ea)) begin
        if (mis_a == 0) begin ah = int'(fb_addr); ae = ea; end
        mis_a++;
      end
    end
    check(mis_h == 0, "R3 hsync over frame (mismatching samples)", mis_h, 0);
    check(mis_v == 0, "R4 vsync over frame (mismatching samples)", mis_v, 0);
    check(vs_low == 2 * H * (VS1 - VS0), "R4 vsync low clocks", vs_low, 2 * H * (VS1 - VS0));
    check(mis_b == 0, "R5 blank over frame (mismatching samples)", mis_b, 0);
    check(mis_g == 0, "R6 R7 R9 gray first mismatch", gh, ge);
    check(mis_a == 0, "R8 fb_addr first mismatch", ah, ae);
    @(negedge clk);
    check(vsync_n === 1'b0, "R2 frame period, vsync again after one frame", int'(vsync_n), 0);
  endtask

  // R10: reset in mid-frame returns outputs and scan to the start
  task automatic t_midrun_reset();
    int period;
    repeat (777) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(blank === 1'b1 && gray === 8'd0, "R10 blank/gray after mid-run reset",
          int'(gray), 0);
    check(fb_addr === '0, "R10 fb_addr after mid-run reset", int'(fb_addr), 0);
    @(negedge clk);
    rst_n = 1'b1;
    period = 0;
    while (hsync_n !== 1'b0) begin period++; @(negedge clk); end
    // first pix_en at the 2nd edge; output of column HS0 appears one pixel later
    check(period >= 2 * HS0 && period <= 2 * HS0 + 3, "R10 scan restarts at column 0",
          period, 2 * HS0 + 2);
  endtask

  initial begin
    t_reset_state();
    t_line_timing();
    t_frame_sweep();
    t_midrun_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule